// File: doc/BRIEF.md
# Multi-Master Bus Arbiter

This block lets several masters share one on-chip bus. Each master raises its own request line. The arbiter answers with a registered grant vector that has at most one bit set. It picks the winner under a priority mode chosen at run time: either the lowest-numbered requester wins, or the requester that was granted least recently wins. The current owner keeps the bus for as long as it holds its busy (lock) input high. A new owner is chosen only at the clock edge where the owner's lock is low, so a hand-over never cuts into an owner's transfer.

The shared address, write-data and control lines are built by AND-OR combining. Each master's outputs are gated with its grant bit and the gated values are ORed together. Every master that does not hold the grant therefore adds zeros, and with no grant the bus is all zeros. All logic runs on one clock. The master count (1 to 16), the address and data widths (32 bits by default) and the control width are parameters.

Top module: `bus_arbiter`

## Requirements
- R1: The grant output `gnt` is registered and has at most one bit set. A bit can newly rise only for a master whose request was high at the clock edge that set it, so the grant follows a request by one cycle.
- R2: With `mode_sel` = 0 (fixed mode), an arbitration grants the requesting master with the lowest index.
- R3: With `mode_sel` = 1 (least-recently-used mode), an arbitration grants the requester that sits earliest in a recency order. A granted master moves to the most-recent end of that order, in either mode.
- R4: While the current owner's `lock` bit is high, `gnt` does not change. The `lock` bits of masters that do not hold the grant have no effect on `gnt`.
- R5: At an edge where the owner's `lock` bit is low, the arbiter arbitrates again among the current requests. The previous owner competes like any other requester and can be granted again.
- R6: At an edge with no request high and no locked owner, `gnt` becomes all zeros.
- R7: `bus_addr`, `bus_wdata` and `bus_ctrl` equal the owner's own address, data and control slices of `m_addr`, `m_wdata` and `m_ctrl`. Master i uses bits [i*W +: W] of each. The bus follows the current grant in the same cycle and is all zeros when no grant is held.
- R8: A synchronous active-low reset (`rst_n` = 0 at an edge) clears `gnt` and sets the recency order to index order, with master 0 as the least recent.
- R9: A change of `mode_sel` takes effect at the next arbitration. The recency history built up beforehand is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Priority mode: 0 fixed, 1 least-recently-used |
| req | input | N_MASTERS | Request line per master |
| lock | input | N_MASTERS | Busy/lock line per master; only the owner's bit is used |
| m_addr | input | N_MASTERS*ADDR_W | Address outputs of all masters, master i at [i*ADDR_W +: ADDR_W] |
| m_wdata | input | N_MASTERS*DATA_W | Write-data outputs of all masters |
| m_ctrl | input | N_MASTERS*CTRL_W | Control outputs of all masters |
| gnt | output | N_MASTERS | Registered grant, one-hot or zero |
| bus_addr | output | ADDR_W | Shared address line |
| bus_wdata | output | DATA_W | Shared write-data line |
| bus_ctrl | output | CTRL_W | Shared control line |

## Verification
The assertions assume that all inputs are stable around each rising edge. They also assume that a high `lock` bit from the owner means the owner is mid-transfer. They assume nothing about whether requests persist. The stimulus changes every input only on the falling edge. In its random phases a master keeps its request up until granted and drives `lock` only for a random tenure once it owns the bus. The `lock` bits of non-owners are randomised to show that they are ignored. An idle phase withdraws every request at once, a saturation phase holds every request high so the least-recently-used mode has to rotate, and a mid-run reset checks that the recency order returns to index order.

// File: rtl/arb_pkg.sv
// Package: shared types and helpers for the bus arbiter.
// Assumes one-hot inputs to onehot_to_idx; a zero vector maps to index 0.
package arb_pkg;

    typedef enum logic {
        ARB_FIXED = 1'b0,
        ARB_LRU   = 1'b1
    } arb_mode_e;

    localparam int MAX_MASTERS = 16;
    localparam int IDX_W       = 4;

    // Convert a one-hot vector of up to MAX_MASTERS bits into its index.
    function automatic logic [IDX_W-1:0] onehot_to_idx(input logic [MAX_MASTERS-1:0] oh);
        logic [IDX_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < MAX_MASTERS; i++) begin
            if (oh[i]) idx = IDX_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/arb_fixed_pick.sv
// Fixed-priority picker: returns a one-hot vector marking the lowest-index
// set bit of req, or zero when req is zero. Purely combinational.
module arb_fixed_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);

    // Scan from the top down so the lowest requesting index is written last.
    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_lru_order.sv
// Least-recently-used picker. Holds a recency list of master indices
// (slot 0 = least recent) and picks the first listed master that requests.
// On upd, master upd_idx is taken out of the list and appended at the end.
// Assumes upd_idx < N whenever upd is high.
module arb_lru_order
    import arb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             upd,
    input  logic [IDX_W-1:0] upd_idx,
    output logic [N-1:0]     pick
);

    logic [IDX_W-1:0] order_q [N];
    logic [IDX_W-1:0] order_d [N];

    // Pick the earliest entry in the recency list whose request is high.
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int k = 0; k < N; k++) begin
            if (!found && req[order_q[k]]) begin
                pick[order_q[k]] = 1'b1;
                found            = 1'b1;
            end
        end
    end

    // Build the next list: close the gap left by upd_idx, append it last.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (order_q[k] == upd_idx) seen = 1'b1;
            if (k == N - 1)
                order_d[k] = upd_idx;
            else if (seen || order_q[k] == upd_idx)
                order_d[k] = order_q[k + 1];
            else
                order_d[k] = order_q[k];
        end
    end

    // Register the list; reset restores index order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) order_q[k] <= IDX_W'(k);
        end else if (upd) begin
            for (int k = 0; k < N; k++) order_q[k] <= order_d[k];
        end
    end

endmodule

// File: rtl/arb_andor_mux.sv
// AND-OR bus combiner: gates each master's W-bit slice with its select bit
// and ORs the results. Assumes sel is one-hot or zero; zero gives all zeros.
module arb_andor_mux #(
    parameter int N = 4,
    parameter int W = 32
) (
    input  logic [N-1:0]   sel,
    input  logic [N*W-1:0] src,
    output logic [W-1:0]   dst
);

    logic [W-1:0] gated [N];

    // One gating term per master.
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = src[i*W +: W] & {W{sel[i]}};
    end

    // OR all gated slices onto the shared line.
    always_comb begin
        dst = '0;
        for (int i = 0; i < N; i++) dst = dst | gated[i];
    end

endmodule

// File: rtl/bus_arbiter.sv
// Multi-master bus arbiter. Registers a one-hot-or-zero grant chosen by
// fixed or LRU priority, holds it while the owner's lock is high, and drives
// the shared bus by AND-OR combining master outputs under the grant.
// Assumes inputs are synchronous to clk; only the owner's lock bit matters.
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_MASTERS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CTRL_W    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_sel,
    input  logic [N_MASTERS-1:0]          req,
    input  logic [N_MASTERS-1:0]          lock,
    input  logic [N_MASTERS*ADDR_W-1:0]   m_addr,
    input  logic [N_MASTERS*DATA_W-1:0]   m_wdata,
    input  logic [N_MASTERS*CTRL_W-1:0]   m_ctrl,
    output logic [N_MASTERS-1:0]          gnt,
    output logic [ADDR_W-1:0]             bus_addr,
    output logic [DATA_W-1:0]             bus_wdata,
    output logic [CTRL_W-1:0]             bus_ctrl
);

    localparam int PAD_W = MAX_MASTERS - N_MASTERS;

    arb_mode_e              mode;
    logic [N_MASTERS-1:0]   gnt_q;
    logic [N_MASTERS-1:0]   fix_pick;
    logic [N_MASTERS-1:0]   lru_pick;
    logic [N_MASTERS-1:0]   win;
    logic                   owner_busy;
    logic                   rearb;
    logic [IDX_W-1:0]       win_idx;

    assign mode       = arb_mode_e'(mode_sel);
    assign owner_busy = |(gnt_q & lock);
    assign rearb      = !owner_busy;

    arb_fixed_pick #(.N(N_MASTERS)) i_fixed (
        .req  (req),
        .pick (fix_pick)
    );

    arb_lru_order #(.N(N_MASTERS)) i_lru (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .upd     (rearb && (|win)),
        .upd_idx (win_idx),
        .pick    (lru_pick)
    );

    // Select the winner according to the current mode.
    always_comb begin
        win = (mode == ARB_LRU) ? lru_pick : fix_pick;
    end

    // Index of the winner, fed to the recency list.
    generate
        if (PAD_W > 0) begin : g_pad
            assign win_idx = onehot_to_idx({{PAD_W{1'b0}}, win});
        end else begin : g_nopad
            assign win_idx = onehot_to_idx(win);
        end
    endgenerate

    // Grant register: hold while the owner is busy, else take the new winner.
    always_ff @(posedge clk) begin
        if (!rst_n)     gnt_q <= '0;
        else if (rearb) gnt_q <= win;
    end

    assign gnt = gnt_q;

    arb_andor_mux #(.N(N_MASTERS), .W(ADDR_W)) i_mux_addr (
        .sel (gnt_q), .src (m_addr), .dst (bus_addr)
    );

    arb_andor_mux #(.N(N_MASTERS), .W(DATA_W)) i_mux_data (
        .sel (gnt_q), .src (m_wdata), .dst (bus_wdata)
    );

    arb_andor_mux #(.N(N_MASTERS), .W(CTRL_W)) i_mux_ctrl (
        .sel (gnt_q), .src (m_ctrl), .dst (bus_ctrl)
    );

endmodule

// File: rtl/bus_arbiter_chk.sv
// Checker for bus_arbiter: observes ports only and checks grant shape,
// hold, priority, idle and reset behaviour. Attached by bind below.
module bus_arbiter_chk #(
    parameter int N_MASTERS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CTRL_W    = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        mode_sel,
    input logic [N_MASTERS-1:0]        req,
    input logic [N_MASTERS-1:0]        lock,
    input logic [N_MASTERS-1:0]        gnt,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [CTRL_W-1:0]           bus_ctrl
);

    // R1
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1
    gnt_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && !$stable(gnt)) |-> (($past(req) & gnt) != '0));

    // R4
    gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt & lock) != '0) |=> $stable(gnt));

    // R2
    fixed_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && (gnt & lock) == '0 && req != '0)
            |=> (gnt == ($past(req) & (~$past(req) + 1'b1))));

    // R6
    idle_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && (gnt & lock) == '0) |=> (gnt == '0));

    // R7
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0) |-> (bus_addr == '0 && bus_wdata == '0 && bus_ctrl == '0));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (gnt == '0));

endmodule

bind bus_arbiter bus_arbiter_chk #(
    .N_MASTERS (N_MASTERS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_W    (CTRL_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .req       (req),
    .lock      (lock),
    .gnt       (gnt),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ctrl  (bus_ctrl)
);

// File: tb/test_bus_arbiter.sv
// Bench for bus_arbiter: a behavioural reference model (queue-based recency
// list) is updated on each rising edge and compared on each falling edge.
module test_bus_arbiter;

    localparam int  N  = 4;
    localparam int  AW = 32;
    localparam int  DW = 32;
    localparam int  CW = 4;
    localparam time CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode_sel = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    lock = '0;
    logic [N*AW-1:0] m_addr = '0;
    logic [N*DW-1:0] m_wdata = '0;
    logic [N*CW-1:0] m_ctrl = '0;
    logic [N-1:0]    gnt;
    logic [AW-1:0]   bus_addr;
    logic [DW-1:0]   bus_wdata;
    logic [CW-1:0]   bus_ctrl;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bus_arbiter #(.N_MASTERS(N), .ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW)) i_bus_arbiter (
        .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .req (req), .lock (lock),
        .m_addr (m_addr), .m_wdata (m_wdata), .m_ctrl (m_ctrl), .gnt (gnt),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ctrl (bus_ctrl)
    );

    // Reference model state
    int           lru_q[$];
    logic [N-1:0] exp_gnt = '0;
    string        exp_tag = "R8";
    logic         last_mode = 1'b0;

    // Model: evaluate the next grant from the inputs seen at this edge.
    always @(posedge clk) begin
        int owner;
        int win;
        int pos;
        if (!rst_n) begin
            exp_gnt = '0;
            lru_q.delete();
            for (int k = 0; k < N; k++) lru_q.push_back(k);
            exp_tag = "R8";
        end else begin
            owner = -1;
            for (int i = 0; i < N; i++) if (exp_gnt[i]) owner = i;
            if (owner >= 0 && lock[owner]) begin
                exp_tag = "R4";
            end else begin
                win = -1;
                if (!mode_sel) begin
                    for (int i = N - 1; i >= 0; i--) if (req[i]) win = i;
                end else begin
                    for (int k = 0; k < lru_q.size(); k++)
                        if (win < 0 && req[lru_q[k]]) win = lru_q[k];
                end
                if (win >= 0) begin
                    exp_gnt      = '0;
                    exp_gnt[win] = 1'b1;
                    pos = 0;
                    for (int k = 0; k < lru_q.size(); k++) if (lru_q[k] == win) pos = k;
                    lru_q.delete(pos);
                    lru_q.push_back(win);
                    if (mode_sel != last_mode) exp_tag = "R9";
                    else if (owner >= 0)       exp_tag = "R5";
                    else if (mode_sel)         exp_tag = "R3";
                    else                       exp_tag = "R2";
                    last_mode = mode_sel;
                end else begin
                    exp_gnt = '0;
                    exp_tag = "R6";
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Compare all outputs with the model (called away from the rising edge).
    task automatic compare();
        logic [AW-1:0] ea;
        logic [DW-1:0] ed;
        logic [CW-1:0] ec;
        ea = '0; ed = '0; ec = '0;
        for (int i = 0; i < N; i++) if (exp_gnt[i]) begin
            ea = m_addr[i*AW +: AW];
            ed = m_wdata[i*DW +: DW];
            ec = m_ctrl[i*CW +: CW];
        end
        check($countones(gnt) <= 1, "R1", 64'(gnt), 64'(exp_gnt));
        check(gnt === exp_gnt, exp_tag, 64'(gnt), 64'(exp_gnt));
        check(bus_addr === ea, "R7 addr", 64'(bus_addr), 64'(ea));
        check(bus_wdata === ed, "R7 data", 64'(bus_wdata), 64'(ed));
        check(bus_ctrl === ec, "R7 ctrl", 64'(bus_ctrl), 64'(ec));
    endtask

    // Stimulus state
    int ten[N];
    bit was_g[N];
    bit idle_mode = 1'b0;
    bit sat_mode  = 1'b0;

    // Drive new inputs for the next cycle.
    task automatic drive();
        cyc++;
        for (int i = 0; i < N; i++) begin
            m_addr[i*AW +: AW]  = AW'(32'hA000_0000 | (i << 24) | (cyc & 32'hFFFF));
            m_wdata[i*DW +: DW] = DW'($urandom);
            m_ctrl[i*CW +: CW]  = CW'(i + 1 + cyc);
            if (idle_mode) begin
                req[i] = 1'b0; lock[i] = 1'b0; was_g[i] = 1'b0;
            end else if (exp_gnt[i]) begin
                if (!was_g[i]) begin ten[i] = int'($urandom % 4); was_g[i] = 1'b1; end
                if (ten[i] > 0) begin
                    lock[i] = 1'b1; ten[i]--;
                end else begin
                    lock[i] = 1'b0;
                    req[i]  = sat_mode ? 1'b1 : ($urandom % 4 == 0);
                end
            end else begin
                was_g[i] = 1'b0;
                lock[i]  = ($urandom % 6 == 0);
                if (sat_mode || (!req[i] && $urandom % 3 == 0)) req[i] = 1'b1;
            end
        end
    endtask

    task automatic step(input int n);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            compare();
            drive();
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin ten[i] = 0; was_g[i] = 1'b0; end
        rst_n = 1'b0;
        step(3);                      // R8: reset state checked
        rst_n = 1'b1;
        mode_sel = 1'b0;
        step(800);                    // R2 fixed mode
        mode_sel = 1'b1;
        step(800);                    // R3 LRU mode
        for (int b = 0; b < 100; b++) begin
            mode_sel = ~mode_sel;     // R9 mode switches
            step(7);
        end
        idle_mode = 1'b1;
        step(20);                     // R6 idle, R7 zero bus
        idle_mode = 1'b0;
        sat_mode  = 1'b1;
        mode_sel  = 1'b1;
        step(300);                    // R3 rotation, R4 holds, R5 regrant
        sat_mode  = 1'b0;
        mode_sel  = 1'b0;
        step(300);                    // R5 owner competes in fixed mode
        @(negedge clk);
        rst_n = 1'b0;                 // R8 mid-run reset restores order
        step(2);
        rst_n = 1'b1;
        mode_sel = 1'b1;
        sat_mode = 1'b1;
        step(200);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule